// File: doc/BRIEF.md
# Shortened Punctured Codeword Assembler

This block builds the 448-bit protected header word of a multi-stream transmitter. It receives 64 already-scrambled header bits and the 168 check bits that an external rate-3/4 LDPC encoder produced for a 504-bit message. That message is the 64 header bits followed by 440 zeros, so the 672-bit mother codeword holds 168 check bits. The block forms two 224-bit codewords by shortening and puncturing. Each keeps the 64 header bits. The first then drops the last eight check bits. The second drops the eight check bits just ahead of those and keeps the final eight. The two codewords are joined into one 448-bit word.

A whitening mask is then XORed onto the word. All masks come from one running sequence of a 7-bit LFSR seeded with all ones. The stream selected at start sets which window of that sequence is used. Stream 1 leaves its first half untouched and masks its second half with the first 224 sequence bits. Each later stream uses the next unused 448 bits. The block reaches its window by clocking the LFSR through the bits it skips, one bit per cycle.

A pulse on the start input launches a job. The result appears with a valid flag, which then holds until the next start.

Top module: `hbcw_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `valid_o` low and `word_o` all zeros.
- R2: Bit order is fixed. Word bit 0 is sent first, `info_i[k]` is header bit k+1, and `parity_i[j]` is check bit p(j+1). For stream 1, `word_o[63:0]` equals the captured `info_i` and `word_o[223:64]` equals the captured `parity_i[159:0]`, with no mask applied.
- R3: Before masking, bits 224..447 hold the second codeword. Bits 224..287 carry `info_i`, bits 288..439 carry `parity_i[151:0]`, and bits 440..447 carry `parity_i[167:160]`.
- R4: The sequence s(1), s(2), ... comes from a 7-bit state loaded with all ones. Each step outputs state[6] XOR state[3] and shifts that bit into state[0], giving x^7+x^4+1. For stream 1, word bit 224+m is XORed with s(m+1) for m = 0..223.
- R5: `stream_sel_i` carries the stream number minus one, so streams 1 to 8 are supported. For stream n ≥ 2, word bit k (0..447) is XORed with s((n-1)*448 - 224 + k + 1).
- R6: When start is sampled at clock edge E, `valid_o` rises right after edge E + n*448, where n is the stream number.
- R7: `valid_o` falls in the cycle after any sampled start. Once high, it stays high and `word_o` stays unchanged until the next start.
- R8: `info_i`, `parity_i` and `stream_sel_i` are captured when start is sampled. Later changes to them do not affect the result of that job.
- R9: A start sampled while a job is running abandons that job. The new job's result follows the timing of R6, counted from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launches a job, sampled at the clock edge |
| stream_sel_i | input | 3 | Stream number minus one |
| info_i | input | 64 | Scrambled header bits, bit 0 first |
| parity_i | input | 168 | LDPC check bits p1..p168 in bits 0..167 |
| word_o | output | 448 | Masked word, bit 0 first |
| valid_o | output | 1 | Result ready, held until next start |

## Verification
The checker tests some properties on every cycle. It checks that the reset state is clean and that valid drops after each start. It checks that valid and the word hold steady between starts. It counts cycles to confirm that valid rises exactly n*448 cycles after start. For stream 1 it checks the unmasked first half against the header and check bits it captured at start. Only the bench's scenarios can show that the masks are correct, since that needs the LFSR sequence window by window for each stream. The same holds for the second codeword's punctured layout, for the capture of inputs that change mid-job, and for the abandon-and-restart path.

// File: rtl/hbcw_pkg.sv
// Shared constants for the codeword assembler: the whitening LFSR
// geometry and its seed. Assumes a 7-bit Fibonacci register.
package hbcw_pkg;
    localparam int LFSR_W   = 7;
    localparam int LFSR_TAP = 4;
    typedef logic [LFSR_W-1:0] lfsr_state_t;
    localparam lfsr_state_t LFSR_SEED = '1;
endpackage

// File: rtl/hbcw_pair_build.sv
// Combinational builder of the two shortened, punctured codewords.
// Half 0: info, then the leading check bits (tail check bits dropped).
// Half 1: info, the leading check bits minus a middle run, then the tail.
// Assumes PAR_W > 2*CUT_W; output bit 0 is the first bit sent.
module hbcw_pair_build #(
    parameter int INFO_W = 64,
    parameter int PAR_W  = 168,
    parameter int CUT_W  = 8
) (
    input  logic [INFO_W-1:0]                    info_i,
    input  logic [PAR_W-1:0]                     par_i,
    output logic [2*(INFO_W+PAR_W-CUT_W)-1:0]    cw_o
);
    localparam int HALF_W = INFO_W + PAR_W - CUT_W;
    localparam int KEEP_A = PAR_W - CUT_W;
    localparam int KEEP_B = PAR_W - 2*CUT_W;

    for (genvar h = 0; h < 2; h++) begin : g_half
        // Both halves start with the header bits.
        assign cw_o[h*HALF_W +: INFO_W] = info_i;
        if (h == 0) begin : g_tail_cut
            // Drop the last CUT_W check bits.
            assign cw_o[INFO_W +: KEEP_A] = par_i[0 +: KEEP_A];
        end else begin : g_mid_cut
            // Drop the middle run, keep the tail.
            assign cw_o[HALF_W + INFO_W +: KEEP_B] = par_i[0 +: KEEP_B];
            assign cw_o[HALF_W + INFO_W + KEEP_B +: CUT_W] = par_i[KEEP_A +: CUT_W];
        end
    end
endmodule

// File: rtl/hbcw_lfsr.sv
// Whitening sequence generator, x^7+x^4+1, all-ones seed.
// bit_o is the output the next step will produce; step advances it.
module hbcw_lfsr
    import hbcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    output logic bit_o
);
    lfsr_state_t st_q;

    assign bit_o = st_q[LFSR_W-1] ^ st_q[LFSR_TAP-1];

    // Reload on reset or job start, otherwise shift on request.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            st_q <= LFSR_SEED;
        end else if (step_i) begin
            st_q <= {st_q[LFSR_W-2:0], bit_o};
        end
    end
endmodule

// File: rtl/hbcw_mask_walker.sv
// Serial mask engine. A job runs (sel+1)*FULL_W cycles. The LFSR steps
// once per cycle after the first HALF_W cycles, and the last FULL_W
// cycles shift mask bits in, with zeros before the sequence starts.
// done_o marks the final cycle; mask_o is the complete mask then.
module hbcw_mask_walker #(
    parameter int HALF_W  = 224,
    parameter int STREAMS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [$clog2(STREAMS)-1:0]   sel_i,
    input  logic                         seq_bit_i,
    output logic                         seq_step_o,
    output logic                         done_o,
    output logic [2*HALF_W-1:0]          mask_o
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(STREAMS * FULL_W);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim_q;
    logic [CNT_W-1:0]  win_q;
    logic [FULL_W-2:0] sr_q;
    logic              in_seq;
    logic              mask_bit;

    assign in_seq     = cnt_q >= CNT_W'(HALF_W);
    assign seq_step_o = busy_q && in_seq;
    assign mask_bit   = in_seq ? seq_bit_i : 1'b0;
    assign mask_o     = {mask_bit, sr_q};
    assign done_o     = busy_q && (cnt_q == lim_q);

    // Job counter: arm on start, stop after the last window bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            lim_q  <= '0;
            win_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            lim_q  <= CNT_W'((int'(sel_i) + 1) * FULL_W - 1);
            win_q  <= CNT_W'(int'(sel_i) * FULL_W);
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (done_o) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Mask shift register: first-sent bit ends in the lowest position.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            sr_q <= '0;
        end else if (busy_q && cnt_q >= win_q) begin
            sr_q <= mask_o[FULL_W-1:1];
        end
    end
endmodule

// File: rtl/hbcw_top.sv
// Codeword assembler top. Captures header and check bits on start,
// builds the two-codeword word, walks the LFSR to the selected
// stream's window and presents word XOR mask with a held valid flag.
// Assumes stream_sel_i = stream number - 1.
module hbcw_top #(
    parameter int INFO_W  = 64,
    parameter int PAR_W   = 168,
    parameter int CUT_W   = 8,
    parameter int STREAMS = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start_i,
    input  logic [$clog2(STREAMS)-1:0]               stream_sel_i,
    input  logic [INFO_W-1:0]                        info_i,
    input  logic [PAR_W-1:0]                         parity_i,
    output logic [2*(INFO_W+PAR_W-CUT_W)-1:0]        word_o,
    output logic                                     valid_o
);
    localparam int HALF_W = INFO_W + PAR_W - CUT_W;
    localparam int FULL_W = 2 * HALF_W;

    logic [INFO_W-1:0] info_q;
    logic [PAR_W-1:0]  par_q;
    logic [FULL_W-1:0] cw;
    logic [FULL_W-1:0] mask;
    logic              seq_bit;
    logic              seq_step;
    logic              done;

    hbcw_pair_build #(.INFO_W(INFO_W), .PAR_W(PAR_W), .CUT_W(CUT_W)) u_build (
        .info_i (info_q),
        .par_i  (par_q),
        .cw_o   (cw)
    );

    hbcw_lfsr u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .step_i (seq_step),
        .bit_o  (seq_bit)
    );

    hbcw_mask_walker #(.HALF_W(HALF_W), .STREAMS(STREAMS)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .sel_i      (stream_sel_i),
        .seq_bit_i  (seq_bit),
        .seq_step_o (seq_step),
        .done_o     (done),
        .mask_o     (mask)
    );

    // Capture inputs on start; publish masked word when the walk ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q  <= '0;
            par_q   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else if (start_i) begin
            info_q  <= info_i;
            par_q   <= parity_i;
            valid_o <= 1'b0;
        end else if (done) begin
            word_o  <= cw ^ mask;
            valid_o <= 1'b1;
        end
    end
endmodule

// File: rtl/hbcw_chk.sv
// Port-level checker for hbcw_top, attached by bind below. Keeps its
// own capture of the start-time inputs and a cycle count since start.
module hbcw_chk #(
    parameter int INFO_W  = 64,
    parameter int PAR_W   = 168,
    parameter int CUT_W   = 8,
    parameter int STREAMS = 8
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  start_i,
    input logic [$clog2(STREAMS)-1:0]            stream_sel_i,
    input logic [INFO_W-1:0]                     info_i,
    input logic [PAR_W-1:0]                      parity_i,
    input logic [2*(INFO_W+PAR_W-CUT_W)-1:0]     word_o,
    input logic                                  valid_o
);
    localparam int HALF_W = INFO_W + PAR_W - CUT_W;
    localparam int FULL_W = 2 * HALF_W;
    localparam int KEEP_A = PAR_W - CUT_W;
    localparam int CYC_W  = $clog2(STREAMS * FULL_W) + 1;

    logic [INFO_W-1:0]          cap_info;
    logic [KEEP_A-1:0]          cap_par;
    logic [$clog2(STREAMS)-1:0] cap_sel;
    logic [CYC_W-1:0]           cyc;
    logic                       armed;

    // Mirror of the start-time inputs and elapsed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_info <= '0;
            cap_par  <= '0;
            cap_sel  <= '0;
            cyc      <= '0;
            armed    <= 1'b0;
        end else if (start_i) begin
            cap_info <= info_i;
            cap_par  <= parity_i[KEEP_A-1:0];
            cap_sel  <= stream_sel_i;
            cyc      <= '0;
            armed    <= 1'b1;
        end else if (armed && !valid_o) begin
            cyc <= cyc + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && word_o == '0));

    p_head_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cap_sel == '0) |->
            (word_o[INFO_W-1:0] == cap_info && word_o[INFO_W +: KEEP_A] == cap_par));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (armed && int'(cyc) == (int'(cap_sel) + 1) * FULL_W));

    p_start_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i) |=> (valid_o && $stable(word_o)));
endmodule

bind hbcw_top hbcw_chk #(
    .INFO_W (INFO_W),
    .PAR_W  (PAR_W),
    .CUT_W  (CUT_W),
    .STREAMS(STREAMS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stream_sel_i (stream_sel_i),
    .info_i       (info_i),
    .parity_i     (parity_i),
    .word_o       (word_o),
    .valid_o      (valid_o)
);

// File: tb/hbcw_top_test.sv
`timescale 1ns/1ps
module hbcw_top_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   stream_sel_i = '0;
    logic [63:0]  info_i = '0;
    logic [167:0] parity_i = '0;
    logic [447:0] word_o;
    logic         valid_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_on = 0;
    string scen = "";

    bit seq [0:4095];

    // reference model state
    bit           m_valid = 0;
    int           m_cnt = 0;
    int           m_n = 1;
    logic [63:0]  m_info = '0;
    logic [167:0] m_par = '0;
    logic [447:0] m_word = '0;

    always #5 clk = ~clk;

    hbcw_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stream_sel_i(stream_sel_i),
        .info_i(info_i), .parity_i(parity_i), .word_o(word_o), .valid_o(valid_o)
    );

    // Whitening sequence from its definition (R4).
    initial begin
        logic [6:0] st;
        st = 7'h7F;
        for (int j = 0; j < 4096; j++) begin
            seq[j] = st[6] ^ st[3];
            st = {st[5:0], seq[j]};
        end
    end

    function automatic logic [447:0] ref_word(logic [63:0] inf, logic [167:0] par, int n);
        logic [447:0] w;
        int h, r, pidx, v;
        logic b;
        for (int k = 0; k < 448; k++) begin
            h = k / 224;
            r = k % 224;
            if (r < 64) b = inf[r];
            else begin
                pidx = r - 64;
                if (h == 1 && pidx >= 152) pidx = pidx + 8;
                b = par[pidx];
            end
            v = (n - 1) * 448 + k - 224;
            w[k] = b ^ ((v >= 0) ? seq[v] : 1'b0);
        end
        return w;
    endfunction

    // Cycle model, advanced on every rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_valid = 0; m_cnt = 0; m_word = '0;
        end else if (start_i) begin
            m_valid = 0;
            m_n = int'(stream_sel_i) + 1;
            m_cnt = m_n * 448;
            m_info = info_i;
            m_par = parity_i;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_valid = 1;
                m_word = ref_word(m_info, m_par, m_n);
            end
        end
    end

    task automatic check(bit ok, string req, logic [447:0] act, logic [447:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check(valid_o == m_valid, {"R6 R7 valid ", scen}, 448'(valid_o), 448'(m_valid));
            if (m_valid) begin
                check(word_o[223:0] == m_word[223:0],
                      {(m_n == 1) ? "R2 first half " : "R5 first half ", scen},
                      448'(word_o[223:0]), 448'(m_word[223:0]));
                check(word_o[447:224] == m_word[447:224],
                      {(m_n == 1) ? "R3 R4 second half " : "R3 R5 second half ", scen},
                      448'(word_o[447:224]), 448'(m_word[447:224]));
            end
        end
    end

    task automatic launch(int sel, logic [63:0] inf, logic [167:0] par);
        @(negedge clk);
        start_i = 1'b1;
        stream_sel_i = 3'(sel);
        info_i = inf;
        parity_i = par;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run(int sel, logic [63:0] inf, logic [167:0] par, int extra);
        launch(sel, inf, par);
        repeat ((sel + 1) * 448 + extra) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && word_o == '0, "R1 reset state", {word_o[446:0], valid_o}, '0);
        rst_n = 1'b1;
        chk_on = 1;

        scen = "stream1";
        run(0, {32'hDEADBEEF, 32'h01234567}, {8'hA5, {5{32'h3C96F00D}}}, 5);
        scen = "stream2";
        run(1, {32'hFFFF0000, 32'h5A5AA5A5}, {8'h3C, {5{32'h81422418}}}, 5);
        scen = "stream8";
        run(7, '1, '1, 5);
        scen = "stream1 zeros";
        run(0, '0, '0, 5);

        scen = "R8 input change mid-job";
        launch(2, {32'h13579BDF, 32'h2468ACE0}, {8'hF0, {5{32'h0F1E2D3C}}});
        repeat (100) @(negedge clk);
        info_i = '1; parity_i = '0; stream_sel_i = 3'd7;
        repeat (3 * 448) @(negedge clk);

        scen = "R9 restart";
        launch(3, {32'hCAFEF00D, 32'h0BADC0DE}, {8'h11, {5{32'h76543210}}});
        repeat (500) @(negedge clk);
        run(0, {32'h00FF00FF, 32'h12121212}, {8'h99, {5{32'hFEDCBA98}}}, 5);

        scen = "R7 hold";
        repeat (60) @(negedge clk);
        scen = "stream5";
        run(4, {32'hA0A0A0A0, 32'h05050505}, {8'h66, {5{32'h55AA33CC}}}, 5);

        chk_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule